// File: doc/BRIEF.md
# Byte-to-Word Packer with Per-Channel Byte Order

This block turns a byte-wide receive stream into 32-bit memory write words. A transfer begins with a start command. The command carries a channel number, an element count, an element size and two address-direction flags. The block then accepts exactly that many bytes over a valid/ready handshake. Every four bytes it emits one word with a four-bit byte strobe. The channel number travels with each word, and the final word of the transfer is marked.

Each channel has a byte-order bit held in a register with separate set and clear write ports. With the bit clear, the earliest byte of each group of four fills the least significant byte lane. With it set, the earliest byte fills the most significant lane. The order is taken from the register when the start command is accepted and then holds for the whole transfer. Some start commands are not allowed: swapped order with a length that is not a whole number of words, swapped order together with either address-decrement flag, or an undefined size code. Such a command raises a configuration-error flag and the transfer never starts. Address generation and memory arbitration belong to the surrounding logic.

Top module: `swap_packer`

## Requirements
- R1: After reset, swapState is all zeros, busy, inReady, outValid and cfgErr are 0.
- R2: A set write ORs swapSetMask into swapState, and a clear write removes the bits of swapClrMask. When both writes name the same bit in one cycle, the clear wins. The result is visible on swapState the next cycle.
- R3: With the channel's swap bit clear, the k-th byte of a word (k = 0..3, counted from the earliest) lands in bits 8k+7:8k, so the bytes 01,02,03,04 give 0x04030201 with strobe 0xF.
- R4: With the channel's swap bit set, the k-th byte lands in bits 31-8k:24-8k, so the bytes 01,02,03,04 give 0x01020304 with strobe 0xF.
- R5: outValid is high for exactly one cycle, in the cycle after the fourth byte of a word (or the last byte of the transfer) is accepted. outChan gives the transfer's channel, and outLast is 1 only on the transfer's final word.
- R6: The byte length is startCount shifted left by startSize (size code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit elements). The byte packing is the same for every size.
- R7: With swap clear, a partial final word has its unused upper bytes at zero and strobe bits set only for the valid low lanes (two bytes give strobe 0x3). Every word that is not the last has strobe 0xF.
- R8: A start on a channel whose swap bit is set, with a byte length that is not a multiple of 4, sets cfgErr and leaves the block idle.
- R9: A start with swap set and startSrcDec or startDstDec high sets cfgErr and leaves the block idle. With swap clear, the decrement flags are accepted and have no effect on packing.
- R10: Size code 3 sets cfgErr and does not start. cfgErr keeps its value until the next start command accepted while idle, which reloads it.
- R11: The byte order of a transfer is the swap bit as it stood before the start cycle. Swap writes in the start cycle or during the transfer do not change that transfer's words.
- R12: inReady equals busy, and bytes offered while idle are not taken. A start command while busy is ignored. A start with count 0 does not start and clears cfgErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swapSetWe | input | 1 | Write strobe for the swap set port |
| swapSetMask | input | NUM_CH | Channels whose swap bit is set |
| swapClrWe | input | 1 | Write strobe for the swap clear port |
| swapClrMask | input | NUM_CH | Channels whose swap bit is cleared |
| swapState | output | NUM_CH | Current per-channel swap bits |
| startValid | input | 1 | Start command strobe (taken while idle) |
| startChan | input | CH_W | Channel of the transfer |
| startCount | input | CNT_W | Number of elements |
| startSize | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| startSrcDec | input | 1 | Source address counts down |
| startDstDec | input | 1 | Destination address counts down |
| cfgErr | output | 1 | Last start command was rejected |
| busy | output | 1 | Transfer in progress |
| inValid | input | 1 | Byte available |
| inData | input | 8 | Received byte |
| inReady | output | 1 | Byte is taken when inValid is also high |
| outValid | output | 1 | Word write strobe |
| outWord | output | 32 | Packed word |
| outStrb | output | 4 | Byte-lane enables of outWord |
| outLast | output | 1 | Final word of the transfer |
| outChan | output | CH_W | Channel of outWord |

## Verification
The case that matters is a swap-register write landing in the same clock cycle as the start command for that channel, because the order decision and the register update then share one edge. The bench raises startValid and a set (or clear) write in one cycle. The scoreboard expects words in the order the bit had before that cycle, and swapState is checked afterwards to show that the write itself still took effect. A clear issued in the middle of a swapped transfer, and a start command issued while busy, are judged the same way against the scoreboard.

// File: rtl/swap_packer_pkg.sv
package swap_packer_pkg;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LANE_W     = 2;

  // element size codes
  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [1:0] SIZE_BAD  = 2'd3;

  typedef enum logic { ST_IDLE, ST_RUN } runState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              take;   // a byte is accepted this cycle
    logic [LANE_W-1:0] lane;   // arrival position inside the word
    logic              swap;   // earliest byte goes to the top lane
    logic              emit;   // word is complete after this byte
    logic              last;   // this byte ends the transfer
  } packCtl_t;

endpackage

// File: rtl/swap_packer_ctrl.sv
module swap_packer_ctrl
  import swap_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 12,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned BLEN_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [CH_W-1:0]   startChan,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [1:0]        startSize,
  input  logic              startSrcDec,
  input  logic              startDstDec,
  input  logic [NUM_CH-1:0] swapBits,
  input  logic              inValid,
  output packCtl_t          ctl,
  output logic              busy,
  output logic [CH_W-1:0]   curChan,
  output logic              cfgErr
);

  runState_t            state;
  logic [BLEN_W-1:0]    remaining;
  logic [LANE_W-1:0]    lane;
  logic                 swapMode;

  logic [BLEN_W-1:0]    byteLen;
  logic                 chanSwap;
  logic                 badCmd;
  logic                 zeroLen;
  logic                 lastByte;

  always_comb begin
    byteLen  = {2'b00, startCount} << startSize;
    chanSwap = swapBits[startChan];
    zeroLen  = (startCount == '0);
    badCmd   = (startSize == SIZE_BAD) ||
               (chanSwap && ((byteLen[1:0] != 2'b00) || startSrcDec || startDstDec));
  end

  assign busy     = (state == ST_RUN);
  assign lastByte = (remaining == BLEN_W'(1));

  always_comb begin
    ctl.take = busy && inValid;
    ctl.lane = lane;
    ctl.swap = swapMode;
    ctl.emit = (lane == LANE_W'(WORD_BYTES - 1)) || lastByte;
    ctl.last = lastByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      lane      <= '0;
      swapMode  <= 1'b0;
      curChan   <= '0;
      cfgErr    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startValid) begin
            cfgErr <= badCmd;
            if (!badCmd && !zeroLen) begin
              state     <= ST_RUN;
              remaining <= byteLen;
              lane      <= '0;
              swapMode  <= chanSwap;
              curChan   <= startChan;
            end
          end
        end
        default: begin
          if (ctl.take) begin
            remaining <= remaining - BLEN_W'(1);
            lane      <= lane + LANE_W'(1);
            if (lastByte) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/swap_packer_dp.sv
module swap_packer_dp
  import swap_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  packCtl_t          ctl,
  input  logic [7:0]        inData,
  input  logic              swapSetWe,
  input  logic [NUM_CH-1:0] swapSetMask,
  input  logic              swapClrWe,
  input  logic [NUM_CH-1:0] swapClrMask,
  output logic [NUM_CH-1:0] swapBits,
  output logic              outValid,
  output logic [31:0]       outWord,
  output logic [3:0]        outStrb,
  output logic              outLast
);

  localparam int unsigned WORD_W = 8 * WORD_BYTES;

  logic [WORD_W-1:0]     acc;
  logic [WORD_BYTES-1:0] strbAcc;
  logic [WORD_W-1:0]     accMerged;
  logic [WORD_BYTES-1:0] strbMerged;
  logic [LANE_W-1:0]     lanePos;
  logic [NUM_CH-1:0]     setBits;
  logic [NUM_CH-1:0]     clrBits;

  // swap register: clear has priority over set on the same bit
  assign setBits = swapSetWe ? swapSetMask : '0;
  assign clrBits = swapClrWe ? swapClrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) swapBits <= '0;
    else       swapBits <= (swapBits | setBits) & ~clrBits;
  end

  // lane the current byte is written to
  assign lanePos = ctl.swap ? (LANE_W'(WORD_BYTES - 1) - ctl.lane) : ctl.lane;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic hit;
    assign hit                 = ctl.take && (lanePos == LANE_W'(g));
    assign accMerged[8*g +: 8] = hit ? inData : acc[8*g +: 8];
    assign strbMerged[g]       = hit | strbAcc[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      strbAcc  <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
      outStrb  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (ctl.take) begin
        if (ctl.emit) begin
          outValid <= 1'b1;
          outWord  <= accMerged;
          outStrb  <= strbMerged;
          outLast  <= ctl.last;
          acc      <= '0;
          strbAcc  <= '0;
        end else begin
          acc     <= accMerged;
          strbAcc <= strbMerged;
        end
      end
    end
  end

endmodule

// File: rtl/swap_packer.sv
module swap_packer
  import swap_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 12,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapSetWe,
  input  logic [NUM_CH-1:0] swapSetMask,
  input  logic              swapClrWe,
  input  logic [NUM_CH-1:0] swapClrMask,
  output logic [NUM_CH-1:0] swapState,
  input  logic              startValid,
  input  logic [CH_W-1:0]   startChan,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [1:0]        startSize,
  input  logic              startSrcDec,
  input  logic              startDstDec,
  output logic              cfgErr,
  output logic              busy,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              outValid,
  output logic [31:0]       outWord,
  output logic [3:0]        outStrb,
  output logic              outLast,
  output logic [CH_W-1:0]   outChan
);

  packCtl_t          ctl;
  logic [NUM_CH-1:0] swapBits;

  swap_packer_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startChan(startChan), .startCount(startCount),
    .startSize(startSize), .startSrcDec(startSrcDec), .startDstDec(startDstDec),
    .swapBits(swapBits), .inValid(inValid),
    .ctl(ctl), .busy(busy), .curChan(outChan), .cfgErr(cfgErr)
  );

  swap_packer_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .swapSetWe(swapSetWe), .swapSetMask(swapSetMask),
    .swapClrWe(swapClrWe), .swapClrMask(swapClrMask),
    .swapBits(swapBits),
    .outValid(outValid), .outWord(outWord), .outStrb(outStrb), .outLast(outLast)
  );

  assign swapState = swapBits;
  assign inReady   = busy;

endmodule

// File: rtl/swap_packer_chk.sv
module swap_packer_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              swapSetWe,
  input logic [NUM_CH-1:0] swapSetMask,
  input logic              swapClrWe,
  input logic [NUM_CH-1:0] swapClrMask,
  input logic [NUM_CH-1:0] swapState,
  input logic              startValid,
  input logic              cfgErr,
  input logic              busy,
  input logic              outValid,
  input logic [3:0]        outStrb,
  input logic              outLast
);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (swapSetWe && !swapClrWe) |=> ((swapState & $past(swapSetMask)) == $past(swapSetMask)));

  assert_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    swapClrWe |=> ((swapState & $past(swapClrMask)) == '0));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_last_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> !busy);

  assert_full_strb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> (outStrb == 4'hF));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busy);

  assert_start_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid));

endmodule

bind swap_packer swap_packer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN),
  .swapSetWe(swapSetWe), .swapSetMask(swapSetMask),
  .swapClrWe(swapClrWe), .swapClrMask(swapClrMask),
  .swapState(swapState), .startValid(startValid),
  .cfgErr(cfgErr), .busy(busy),
  .outValid(outValid), .outStrb(outStrb), .outLast(outLast)
);

// File: tb/swap_packer_test.sv
`timescale 1ns/1ps
module swap_packer_test;

  localparam int NUM_CH = 8;
  localparam int CNT_W  = 12;
  localparam int CH_W   = 3;

  typedef struct packed {
    logic [31:0]     w;
    logic [3:0]      s;
    logic            l;
    logic [CH_W-1:0] c;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              swapSetWe = 1'b0, swapClrWe = 1'b0;
  logic [NUM_CH-1:0] swapSetMask = '0, swapClrMask = '0;
  logic [NUM_CH-1:0] swapState;
  logic              startValid = 1'b0;
  logic [CH_W-1:0]   startChan = '0;
  logic [CNT_W-1:0]  startCount = '0;
  logic [1:0]        startSize = '0;
  logic              startSrcDec = 1'b0, startDstDec = 1'b0;
  logic              cfgErr, busy, inReady, outValid, outLast;
  logic              inValid = 1'b0;
  logic [7:0]        inData = '0;
  logic [31:0]       outWord;
  logic [3:0]        outStrb;
  logic [CH_W-1:0]   outChan;

  int compared = 0;
  int mismatched = 0;
  item_t expQ[$];

  always #4 clk = ~clk;

  swap_packer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each emitted word
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected word", {28'd0, outStrb, outWord}, 64'd0);
      end else begin
        item_t e;
        item_t a;
        e = expQ.pop_front();
        a = '{w: outWord, s: outStrb, l: outLast, c: outChan};
        check(a == e, "R3/R4/R5/R6/R7/R11 word", 64'(a), 64'(e));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic swapWrite(input bit doSet, input logic [NUM_CH-1:0] sm, input bit doClr, input logic [NUM_CH-1:0] cm);
    swapSetWe = doSet; swapSetMask = sm; swapClrWe = doClr; swapClrMask = cm;
    @(negedge clk);
    swapSetWe = 1'b0; swapClrWe = 1'b0;
  endtask

  task automatic startCmd(input int ch, input int cnt, input int sz, input bit sd, input bit dd);
    startValid = 1'b1; startChan = CH_W'(ch); startCount = CNT_W'(cnt);
    startSize = 2'(sz); startSrcDec = sd; startDstDec = dd;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    inValid = 1'b1; inData = b;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // expected words of a transfer of len bytes base, base+1, ...
  task automatic pushExpected(input int ch, input int len, input logic [7:0] base, input bit sw);
    int nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      item_t e;
      e.w = '0; e.s = '0; e.c = CH_W'(ch); e.l = (w == nw - 1);
      for (int k = 0; k < 4; k++) begin
        int g = 4 * w + k;
        if (g < len) begin
          int pos = sw ? 3 - k : k;
          e.w[8*pos +: 8] = base + 8'(g);
          e.s[pos] = 1'b1;
        end
      end
      expQ.push_back(e);
    end
  endtask

  task automatic sendAll(input int len, input logic [7:0] base);
    for (int g = 0; g < len; g++) sendByte(base + 8'(g));
  endtask

  task automatic runXfer(input int ch, input int cnt, input int sz, input logic [7:0] base, input bit sw);
    int len = cnt << sz;
    pushExpected(ch, len, base, sw);
    startCmd(ch, cnt, sz, 1'b0, 1'b0);
    sendAll(len, base);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (still in reset)
    check(swapState == '0, "R1 swapState", 64'(swapState), 0);
    check({busy, inReady, outValid, cfgErr} == 4'b0, "R1 flags", 64'({busy, inReady, outValid, cfgErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, inReady, outValid, cfgErr} == 4'b0, "R1 after release", 64'({busy, inReady, outValid, cfgErr}), 0);

    // R12 bytes offered while idle are not taken
    inValid = 1'b1; inData = 8'hEE;
    repeat (2) @(negedge clk);
    check(!inReady, "R12 inReady idle", 64'(inReady), 0);
    inValid = 1'b0;

    // R3 plain order, 01..04 then 05..08
    runXfer(0, 8, 0, 8'h01, 1'b0);

    // R2 set/clear, clear wins on shared bit
    swapWrite(1'b1, 8'b0000_0110, 1'b0, '0);
    check(swapState == 8'b0000_0110, "R2 set", 64'(swapState), 64'h06);
    swapWrite(1'b1, 8'b1000_1000, 1'b1, 8'b1000_0010);
    check(swapState == 8'b0000_1100, "R2 set+clr clear wins", 64'(swapState), 64'h0C);

    // R4 swapped order on channel 2, R6 word-size elements
    runXfer(2, 2, 2, 8'h01, 1'b1);
    // R6 halfword elements, swap clear on channel 1
    runXfer(1, 4, 1, 8'h20, 1'b0);

    // R7 partial final word: 6 bytes, then 1 byte
    runXfer(1, 6, 0, 8'h40, 1'b0);
    runXfer(5, 1, 0, 8'h7A, 1'b0);
    // R9 decrement with swap clear is accepted
    pushExpected(1, 4, 8'h90, 1'b0);
    startCmd(1, 4, 0, 1'b1, 1'b1);
    check(busy && !cfgErr, "R9 decrement no swap starts", 64'({busy, cfgErr}), 64'h2);
    sendAll(4, 8'h90);
    repeat (2) @(negedge clk);

    // R8 swap with length not multiple of 4
    startCmd(2, 3, 1, 1'b0, 1'b0);
    check(cfgErr && !busy, "R8 bad length", 64'({cfgErr, busy}), 64'h2);
    repeat (3) @(negedge clk);
    check(cfgErr, "R10 error held", 64'(cfgErr), 1);
    // R12 zero count clears error, does not start
    startCmd(2, 0, 0, 1'b0, 1'b0);
    check(!cfgErr && !busy, "R12 zero count", 64'({cfgErr, busy}), 0);
    // R9 swap with source decrement, then destination decrement
    startCmd(3, 4, 0, 1'b1, 1'b0);
    check(cfgErr && !busy, "R9 swap+src dec", 64'({cfgErr, busy}), 64'h2);
    startCmd(3, 4, 0, 1'b0, 1'b1);
    check(cfgErr && !busy, "R9 swap+dst dec", 64'({cfgErr, busy}), 64'h2);
    // R10 illegal size code
    startCmd(0, 4, 3, 1'b0, 1'b0);
    check(cfgErr && !busy, "R10 size code 3", 64'({cfgErr, busy}), 64'h2);
    check(!inReady, "R12 inReady after reject", 64'(inReady), 0);

    // R11 set write in the start cycle: old order (clear) applies
    pushExpected(6, 4, 8'hA0, 1'b0);
    swapSetWe = 1'b1; swapSetMask = 8'b0100_0000;
    startCmd(6, 4, 0, 1'b0, 1'b0);
    swapSetWe = 1'b0;
    check(!cfgErr, "R11 start cleared error", 64'(cfgErr), 0);
    sendAll(4, 8'hA0);
    repeat (2) @(negedge clk);
    check(swapState[6], "R11 set took effect", 64'(swapState), 64'h4C);

    // R11 clear during a swapped transfer; R12 start while busy ignored
    pushExpected(3, 8, 8'hC0, 1'b1);
    startCmd(3, 2, 2, 1'b0, 1'b0);
    sendAll(2, 8'hC0);
    swapWrite(1'b0, '0, 1'b1, 8'b0000_1000);
    startCmd(5, 1, 0, 1'b0, 1'b0);
    check(busy, "R12 still busy after ignored start", 64'(busy), 1);
    sendAll(6, 8'hC2);
    repeat (3) @(negedge clk);
    check(!busy && !swapState[3], "R11/R12 end state", 64'({busy, swapState[3]}), 0);

    // R3 after clear: channel 3 now plain
    runXfer(3, 4, 0, 8'h01, 1'b0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5 all words seen", 64'(expQ.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule